// File: doc/BRIEF.md
# Pipelined Debug Register Access Chain

This block is a 40-bit data-register scan chain. Through it a debug host reads and writes a small internal bank of debug registers: breakpoint value and control pairs, watchpoint value and control pairs, and one vector catch register. The chain runs on the test clock. It takes the capture, shift and update strobes from the TAP controller, a chain-selected qualifier, and an access-enable qualifier that is high while the write-capable test instruction is loaded.

Each scan carries one request into the block: a write flag, a data word and an address. The same scan carries out the result of the request submitted on the scan before it. On the way out, the bit that held the write flag holds a Ready flag. A request is taken at the update strobe and finishes on the next clock, unless a stall input holds it back. Because results come back one scan late, a host ends every batch with a dummy write of data 0 to address 0, which is a no-op.

A combinational peek port shows any register by address, so the bank can be observed directly. The bit 0 of each control register is brought out as the enable of its breakpoint or watchpoint unit.

Top module: `dbgsc_chain`

## Requirements
- R1: The chain is 40 bits long and is shifted least significant bit first. Going in, bit 0 is the write flag (1 = write, 0 = read), bits 32..1 are data and bits 39..33 are the address. Coming out, bit 0 is Ready, bits 32..1 are result data and bits 39..33 are the result address.
- R2: An update strobe submits the shifted request only when chain-select and access-enable are both high. A submitted request completes on the next clock edge at which stall is low.
- R3: A capture strobe loads Ready as 1 when no request is pending and 0 otherwise. It also loads the address and data of the last completed request: the read value for a read, the written value for a write. A capture on the same edge as a completion sees the state from before that completion.
- R4: The address map is: 7 = vector catch, 64+n = breakpoint value n, 80+n = breakpoint control n (n < 6), 96+n = watchpoint value n, 112+n = watchpoint control n (n < 2).
- R5: A write to any other address, including the no-op address 0, changes no register, and its write data is still echoed. A read from any such address returns 0.
- R6: After reset every register, the stored result and the pending state are 0, so the first capture gives Ready 1, data 0 and address 0.
- R7: While stall is high a pending request stays pending and captures give Ready 0. An update strobe that arrives while a request is pending is discarded.
- R8: With access-enable low, an update submits nothing, while capture and shift still work. With chain-select low, all three strobes are ignored.
- R9: Breakpoint enable n equals bit 0 of breakpoint control n, and watchpoint enable n equals bit 0 of watchpoint control n. Writing 0 to a control register disables its unit.
- R10: The peek port returns the current contents of the register at the peek address, and 0 for an address that has no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | This chain is the selected data register |
| access_en_i | input | 1 | Write-capable test instruction loaded; allows submission |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (chain bit 0) |
| stall_i | input | 1 | Holds a pending access from completing |
| peek_addr_i | input | 7 | Peek port address |
| peek_data_o | output | 32 | Peek port data |
| bp_en_o | output | NUM_BP | Breakpoint unit enables |
| wp_en_o | output | NUM_WP | Watchpoint unit enables |

## Verification
The two functions that can fall in the same cycle are the capture of a new scan and the completion of the previous request. The bench provokes this by starting a capture on the clock right after an update. The captured scan must then show Ready 0 and the older result. The next scan must return the result of the request made in between, and the peek port must show that the skipped write still landed. A second overlap, an update arriving while a stalled request is pending, is judged by checking that the stalled write alone takes effect and that the discarded target keeps its old value.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
   localparam int unsigned ADDR_W  = 7;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned CHAIN_W = 1 + DATA_W + ADDR_W;
   localparam int unsigned NUM_ADDR = 1 << ADDR_W;

   // register map bases (R4)
   localparam int unsigned A_VCATCH = 7;
   localparam int unsigned A_BVAL   = 64;
   localparam int unsigned A_BCTL   = 80;
   localparam int unsigned A_WVAL   = 96;
   localparam int unsigned A_WCTL   = 112;
   localparam int unsigned BANK_SPAN = 16;

   // chain image: bit 0 = write flag, then data, then address (R1)
   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
      logic              wr;
   } req_t;
endpackage

// File: rtl/dbgsc_shift.sv
module dbgsc_shift #(
   parameter int unsigned W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         shf,
   input  logic [W-1:0] cap_val,
   input  logic         tdi,
   output logic [W-1:0] sr_q,
   output logic         tdo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sr_q <= '0;
      else if (cap) sr_q <= cap_val;
      else if (shf) sr_q <= {tdi, sr_q[W-1:1]};
   end

   assign tdo = sr_q[0];

   // R1: serial data enters at the far end of the chain
   a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (shf && !cap) |=> sr_q[W-1] == $past(tdi));
endmodule

// File: rtl/dbgsc_regbank.sv
module dbgsc_regbank
   import dbgsc_pkg::*;
#(
   parameter int unsigned NUM_BP = 6,
   parameter int unsigned NUM_WP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b,
   output logic [NUM_BP-1:0] bp_en,
   output logic [NUM_WP-1:0] wp_en
);
   logic [NUM_BP-1:0][DATA_W-1:0] bval_w, bctl_w;
   logic [NUM_WP-1:0][DATA_W-1:0] wval_w, wctl_w;
   logic [DATA_W-1:0]             vcatch_q;
   logic [DATA_W-1:0]             view [NUM_ADDR];

   function automatic logic hit(input logic w, input logic [ADDR_W-1:0] a,
                                input int unsigned target);
      return w && (a == ADDR_W'(target));
   endfunction

   generate
      for (genvar n = 0; n < NUM_BP; n++) begin : g_bp
         logic [DATA_W-1:0] val_q, ctl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               ctl_q <= '0;
            end else begin
               if (hit(we, waddr, A_BVAL + n)) val_q <= wdata;
               if (hit(we, waddr, A_BCTL + n)) ctl_q <= wdata;
            end
         end
         assign bval_w[n] = val_q;
         assign bctl_w[n] = ctl_q;
         assign bp_en[n]  = ctl_q[0];
      end
      for (genvar n = 0; n < NUM_WP; n++) begin : g_wp
         logic [DATA_W-1:0] val_q, ctl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               ctl_q <= '0;
            end else begin
               if (hit(we, waddr, A_WVAL + n)) val_q <= wdata;
               if (hit(we, waddr, A_WCTL + n)) ctl_q <= wdata;
            end
         end
         assign wval_w[n] = val_q;
         assign wctl_w[n] = ctl_q;
         assign wp_en[n]  = ctl_q[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vcatch_q <= '0;
      else if (hit(we, waddr, A_VCATCH)) vcatch_q <= wdata;
   end

   // address-indexed view; holes read as zero
   always_comb begin
      view = '{default: '0};
      view[ADDR_W'(A_VCATCH)] = vcatch_q;
      for (int n = 0; n < int'(NUM_BP); n++) begin
         view[ADDR_W'(A_BVAL + n)] = bval_w[n];
         view[ADDR_W'(A_BCTL + n)] = bctl_w[n];
      end
      for (int n = 0; n < int'(NUM_WP); n++) begin
         view[ADDR_W'(A_WVAL + n)] = wval_w[n];
         view[ADDR_W'(A_WCTL + n)] = wctl_w[n];
      end
   end

   assign rdata_a = view[raddr_a];
   assign rdata_b = view[raddr_b];

   // R5: the no-op address never holds data
   a_r5_noop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (raddr_b == '0) |-> (rdata_b == '0));
endmodule

// File: rtl/dbgsc_seq.sv
module dbgsc_seq
   import dbgsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              submit,
   input  req_t              req_in,
   input  logic [DATA_W-1:0] rd_data,
   output logic              pending,
   output req_t              req_q,
   output logic              we,
   output logic [ADDR_W-1:0] res_addr,
   output logic [DATA_W-1:0] res_data
);
   logic done;

   assign done = pending && !stall;
   assign we   = done && req_q.wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         req_q    <= '0;
         res_addr <= '0;
         res_data <= '0;
      end else begin
         if (done) begin
            pending  <= 1'b0;
            res_addr <= req_q.addr;
            res_data <= req_q.wr ? req_q.data : rd_data;
         end
         if (submit && !pending) begin
            pending <= 1'b1;
            req_q   <= req_in;
         end
      end
   end

   // R2: an unstalled access takes exactly one cycle
   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !stall && !submit) |=> !pending);
   // R7: stall freezes the pending request
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && stall) |=> (pending && $stable(req_q)));
   // R3: the completed address becomes the result address
   a_r3_result_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !stall) |=> (res_addr == $past(req_q.addr)));
endmodule

// File: rtl/dbgsc_chain.sv
module dbgsc_chain
   import dbgsc_pkg::*;
#(
   parameter int unsigned NUM_BP = 6,
   parameter int unsigned NUM_WP = 2
) (
   input  logic              tck_i,
   input  logic              rst_n_i,
   input  logic              sel_i,
   input  logic              access_en_i,
   input  logic              capture_i,
   input  logic              shift_i,
   input  logic              update_i,
   input  logic              tdi_i,
   output logic              tdo_o,
   input  logic              stall_i,
   input  logic [ADDR_W-1:0] peek_addr_i,
   output logic [DATA_W-1:0] peek_data_o,
   output logic [NUM_BP-1:0] bp_en_o,
   output logic [NUM_WP-1:0] wp_en_o
);
   generate
      if (NUM_BP < 1 || NUM_BP > BANK_SPAN) begin : g_bad_bp
         $error("NUM_BP must lie in 1..16");
      end
      if (NUM_WP < 1 || NUM_WP > BANK_SPAN) begin : g_bad_wp
         $error("NUM_WP must lie in 1..16");
      end
   endgenerate

   logic              cap_en, shf_en, upd_en;
   logic [CHAIN_W-1:0] sr_q, cap_val;
   logic              pending, we;
   req_t              req_q;
   logic [ADDR_W-1:0] res_addr;
   logic [DATA_W-1:0] res_data, rd_data;

   assign cap_en = sel_i && capture_i;
   assign shf_en = sel_i && shift_i;
   assign upd_en = sel_i && update_i && access_en_i;

   assign cap_val = {res_addr, res_data, !pending};

   dbgsc_shift #(.W(CHAIN_W)) u_shift (
      .clk(tck_i), .rst_n(rst_n_i), .cap(cap_en), .shf(shf_en),
      .cap_val(cap_val), .tdi(tdi_i), .sr_q(sr_q), .tdo(tdo_o)
   );

   dbgsc_seq u_seq (
      .clk(tck_i), .rst_n(rst_n_i), .stall(stall_i), .submit(upd_en),
      .req_in(req_t'(sr_q)), .rd_data(rd_data), .pending(pending),
      .req_q(req_q), .we(we), .res_addr(res_addr), .res_data(res_data)
   );

   dbgsc_regbank #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_bank (
      .clk(tck_i), .rst_n(rst_n_i), .we(we), .waddr(req_q.addr),
      .wdata(req_q.data), .raddr_a(req_q.addr), .rdata_a(rd_data),
      .raddr_b(peek_addr_i), .rdata_b(peek_data_o),
      .bp_en(bp_en_o), .wp_en(wp_en_o)
   );

   // R3: Ready seen at the port reflects the pending state before capture
   a_r3_ready_capture: assert property (@(posedge tck_i) disable iff (!rst_n_i)
      cap_en |=> (tdo_o == !$past(pending)));
   // R8: without chain select the chain holds still
   a_r8_unselected: assert property (@(posedge tck_i) disable iff (!rst_n_i)
      !sel_i |=> $stable(sr_q));
endmodule

// File: tb/dbgsc_chain_tb.sv
module dbgsc_chain_tb;
   localparam int TCK_PERIOD = 10;
   localparam int NBP = 6;
   localparam int NWP = 2;

   logic        tck = 0, rst_n = 0, sel = 1, acc = 1;
   logic        cap = 0, shf = 0, upd = 0, tdi = 0, stall = 0;
   logic        tdo;
   logic [6:0]  peek_addr = '0;
   logic [31:0] peek_data;
   logic [NBP-1:0] bp_en;
   logic [NWP-1:0] wp_en;

   int nchk = 0, nfail = 0;
   logic [31:0] model [128];
   logic [6:0]  exp_a;
   logic [31:0] exp_d;

   always #(TCK_PERIOD/2) tck = ~tck;

   dbgsc_chain #(.NUM_BP(NBP), .NUM_WP(NWP)) u_dut (
      .tck_i(tck), .rst_n_i(rst_n), .sel_i(sel), .access_en_i(acc),
      .capture_i(cap), .shift_i(shf), .update_i(upd), .tdi_i(tdi),
      .tdo_o(tdo), .stall_i(stall), .peek_addr_i(peek_addr),
      .peek_data_o(peek_data), .bp_en_o(bp_en), .wp_en_o(wp_en)
   );

   function automatic bit impl(int a);
      return a == 7 || (a >= 64 && a < 64 + NBP) || (a >= 80 && a < 80 + NBP)
          || (a >= 96 && a < 96 + NWP) || (a >= 112 && a < 112 + NWP);
   endfunction

   function automatic logic [31:0] pat(int a, int k);
      return 32'h9E3779B9 * 32'(a + 1) + 32'(k * 7919);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] want);
      nchk++;
      if (got !== want) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", tag, got, want);
      end
   endtask

   // one complete scan; starts and ends at a falling edge
   task automatic scan(input logic wr, input logic [31:0] d, input logic [6:0] a,
                       input int gap, output logic [39:0] got);
      logic [39:0] send;
      send = {a, d, wr};
      cap = 1;
      @(posedge tck); @(negedge tck);
      cap = 0; shf = 1;
      for (int i = 0; i < 40; i++) begin
         got[i] = tdo;
         tdi = send[i];
         @(posedge tck); @(negedge tck);
      end
      shf = 0; upd = 1;
      @(posedge tck); @(negedge tck);
      upd = 0;
      repeat (gap) begin @(posedge tck); @(negedge tck); end
   endtask

   task automatic resp(string tag, logic [39:0] got, logic rdy, logic [6:0] a, logic [31:0] d);
      chk({tag, " ready"}, 32'(got[0]), 32'(rdy));
      chk({tag, " data"}, got[32:1], d);
      chk({tag, " addr"}, 32'(got[39:33]), 32'(a));
   endtask

   // record the result a completed request leaves behind
   task automatic nxt(logic wr, logic [31:0] d, logic [6:0] a);
      exp_a = a;
      exp_d = wr ? d : (impl(int'(a)) ? model[a] : 32'h0);
      if (wr && impl(int'(a))) model[a] = d;
   endtask

   task automatic xfer(string tag, logic wr, logic [31:0] d, logic [6:0] a);
      logic [39:0] got;
      scan(wr, d, a, 2, got);
      resp(tag, got, 1'b1, exp_a, exp_d);
      nxt(wr, d, a);
   endtask

   task automatic peek_all(string tag);
      for (int a = 0; a < 128; a++) begin
         peek_addr = 7'(a);
         #1;
         chk(tag, peek_data, impl(a) ? model[a] : 32'h0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [39:0] got;
      logic [6:0]  sa;
      logic [31:0] sd;
      for (int a = 0; a < 128; a++) model[a] = '0;
      exp_a = '0; exp_d = '0;
      repeat (3) @(negedge tck);
      rst_n = 1;
      @(negedge tck);

      // R6: reset state on peek port and enables
      peek_all("R6 reset peek");
      chk("R6 reset bp_en", 32'(bp_en), 0);
      chk("R6 reset wp_en", 32'(wp_en), 0);
      // R6: first capture gives Ready 1 and an empty result
      xfer("R6 first scan", 1'b1, 32'h0, 7'd0);

      // R1 R4 R5: write sweep over every address; each scan echoes the previous write
      for (int a = 0; a < 128; a++) xfer("R1 R5 write sweep", 1'b1, pat(a, 1), 7'(a));
      // R4 R5: read sweep; reads of holes return 0
      for (int a = 0; a < 128; a++) xfer("R4 R5 read sweep", 1'b0, 32'h0, 7'(a));
      xfer("R4 flush", 1'b1, 32'h0, 7'd0);
      // R10: peek port mirrors the bank
      peek_all("R10 peek after sweep");

      // R9: enables follow control bit 0
      for (int n = 0; n < NBP; n++) chk("R9 bp_en sweep", 32'(bp_en[n]), 32'(model[80+n][0]));
      for (int n = 0; n < NWP; n++) chk("R9 wp_en sweep", 32'(wp_en[n]), 32'(model[112+n][0]));
      for (int n = 0; n < NBP; n++) xfer("R9 set bctl", 1'b1, 32'h1, 7'(80 + n));
      for (int n = 0; n < NWP; n++) xfer("R9 set wctl", 1'b1, 32'h3, 7'(112 + n));
      chk("R9 bp_en all on", 32'(bp_en), (1 << NBP) - 1);
      chk("R9 wp_en all on", 32'(wp_en), (1 << NWP) - 1);
      for (int n = 0; n < NBP; n += 2) xfer("R9 clear bctl", 1'b1, 32'h0, 7'(80 + n));
      xfer("R9 clear wctl", 1'b1, 32'h0, 7'd113);
      chk("R9 bp_en partial", 32'(bp_en), 32'b101010);
      chk("R9 wp_en partial", 32'(wp_en), 32'b01);

      // R7: stalled request blocks Ready and discards a second update
      stall = 1;
      sa = exp_a; sd = exp_d;
      scan(1'b1, 32'hCAFE0064, 7'd64, 2, got);
      resp("R7 stall submit", got, 1'b1, sa, sd);
      scan(1'b1, 32'hBAD00065, 7'd65, 2, got);
      resp("R7 stalled capture", got, 1'b0, sa, sd);
      stall = 0;
      @(posedge tck); @(negedge tck);
      nxt(1'b1, 32'hCAFE0064, 7'd64);
      xfer("R7 after stall", 1'b1, 32'h0, 7'd0);
      peek_addr = 7'd65; #1;
      chk("R7 discarded update", peek_data, model[65]);
      peek_addr = 7'd64; #1;
      chk("R7 stalled write landed", peek_data, 32'hCAFE0064);

      // R8: access-enable low submits nothing
      acc = 0;
      scan(1'b1, 32'h1111_2222, 7'd66, 2, got);
      resp("R8 no access", got, 1'b1, exp_a, exp_d);
      acc = 1;
      xfer("R8 result unchanged", 1'b1, 32'h0, 7'd0);
      peek_addr = 7'd66; #1;
      chk("R8 reg untouched", peek_data, model[66]);
      // R8: chain-select low ignores all strobes
      sel = 0;
      scan(1'b1, 32'h3333_4444, 7'd97, 2, got);
      sel = 1;
      xfer("R8 unselected result", 1'b1, 32'h0, 7'd0);
      peek_addr = 7'd97; #1;
      chk("R8 unselected reg", peek_data, model[97]);

      // R3: capture on the same edge as completion sees the older state
      sa = exp_a; sd = exp_d;
      scan(1'b1, 32'h7777_0007, 7'd7, 0, got);
      resp("R3 overlap submit", got, 1'b1, sa, sd);
      scan(1'b1, 32'h0, 7'd0, 2, got);
      resp("R3 overlap capture", got, 1'b0, sa, sd);
      nxt(1'b1, 32'h7777_0007, 7'd7);
      nxt(1'b1, 32'h0, 7'd0);
      xfer("R3 after overlap", 1'b0, 32'h0, 7'd7);
      xfer("R3 readback", 1'b1, 32'h0, 7'd0);
      peek_addr = 7'd7; #1;
      chk("R3 overlapped write landed", peek_data, 32'h7777_0007);

      // R2: read straight after write of a value register
      xfer("R2 write wval", 1'b1, 32'h5A5A_0096, 7'd96);
      xfer("R2 read wval", 1'b0, 32'h0, 7'd96);
      xfer("R2 flush", 1'b1, 32'h0, 7'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule